// File: doc/BRIEF.md
# Page Write Collector with Column Wrap

This block gathers the data bytes of a single memory-write command and then writes them into one 32-byte page of a 4096-byte array. The address given with the start strobe picks the page (upper seven bits) and the first column (lower five bits). Each accepted byte lands at the current column, and the column then advances. Past column 31 it returns to column 0 of the same page. A burst longer than a page therefore overwrites its own earliest bytes, and only the most recent 32 bytes survive.

A per-column loaded mask records which columns received data. When the command decoder signals commit and the protection logic allows it, the block writes only the marked columns to the array write port. It writes one byte per clock, in ascending column order, and then pulses done. Columns that were never loaded are not touched, so partial page writes keep the rest of the page intact. An abort, or a commit while the allowed input is low, discards the collected data and writes nothing. Framing of whole bytes and protection decisions are made upstream.

Top module: `page_wbuf`

## Requirements
- R1: After reset no write is issued, `done_o` is low and `busy_o` is low.
- R2: A start strobe while idle sets the page to `start_addr_i[11:5]` and the first column to `start_addr_i[4:0]`, with an empty loaded mask.
- R3: Each byte strobe while loading stores the byte at the current column and marks it loaded. The column then advances, going from 31 back to 0 on the same page.
- R4: When more than 32 bytes arrive in one command, each column is written once, holding the last byte received for it.
- R5: A commit with `commit_ok_i` high writes exactly the loaded columns, one per clock on consecutive clocks, in ascending column order, all to the start page at address `{page, column}`. The rest of the array is unchanged.
- R6: `done_o` is a one-cycle pulse in the cycle after the last write. A permitted commit with nothing loaded gives a done pulse and no write.
- R7: An abort, or a commit with `commit_ok_i` low, while loading returns the block to idle without any write or done pulse. Abort takes priority over commit, and commit takes priority over start.
- R8: `busy_o` is high from the cycle after an accepted commit until the done pulse. During that time start, byte, commit and abort inputs are ignored.
- R9: Byte, commit and abort strobes while idle have no effect. A start strobe while loading discards the bytes collected so far and begins a new command.
- R10: A byte strobe in the same cycle as a commit is included in the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a command at `start_addr_i` |
| start_addr_i | input | 12 | Start address: page in bits 11:5, column in bits 4:0 |
| byte_vld_i | input | 1 | A complete data byte is present |
| byte_i | input | 8 | Data byte |
| commit_i | input | 1 | End of command, request write |
| commit_ok_i | input | 1 | Protection allows the write |
| abort_i | input | 1 | Discard the command |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | 12 | Array write address |
| wr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Flush in progress |
| done_o | output | 1 | One-cycle pulse after the flush |

## Verification
The assertions check these properties on every cycle: writes occur only while busy, consecutive writes stay on one page with strictly rising columns, done is a single isolated pulse that ends every busy period, and an abort never starts a flush. Only the bench scenarios can show which bytes reach which addresses. This covers wrap-around from every start column, overlong bursts keeping their last bytes, and untouched columns keeping their old contents. The bench also compares the whole array against an arithmetic model after each command, including the discard cases.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FLUSH = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/pwb_first_set.sv
module pwb_first_set #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/pwb_byte_store.sv
module pwb_byte_store #(
    parameter int COL_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [COL_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [COL_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << COL_W;

    logic [DEPTH-1:0][DATA_W-1:0] cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (we_i) begin
            cell_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign rdata_o = cell_q[ridx_i];
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
    import pwb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              commit_i,
    input  logic              commit_ok_i,
    input  logic              abort_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int PAGE_BYTES = 1 << COL_W;
    localparam int ROW_W      = ADDR_W - COL_W;

    typedef struct packed {
        pwb_state_e            state;
        logic [ROW_W-1:0]      row;
        logic [COL_W-1:0]      col;
        logic [PAGE_BYTES-1:0] mask;
        logic                  wr_en;
        logic [ADDR_W-1:0]     wr_addr;
        logic [DATA_W-1:0]     wr_data;
        logic                  done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              st_we;
    logic [COL_W-1:0]  pick_idx;
    logic              pick_any;
    logic [DATA_W-1:0] pick_data;

    pwb_first_set #(
        .N     (PAGE_BYTES),
        .IDX_W (COL_W)
    ) u_pick (
        .vec_i (ctl_q.mask),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    pwb_byte_store #(
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_we),
        .widx_i  (ctl_q.col),
        .wdata_i (byte_i),
        .ridx_i  (pick_idx),
        .rdata_o (pick_data)
    );

    always_comb begin
        logic [PAGE_BYTES-1:0] mask_n;
        logic [COL_W-1:0]      col_n;

        ctl_d       = ctl_q;
        ctl_d.wr_en = 1'b0;
        ctl_d.done  = 1'b0;
        st_we       = 1'b0;
        mask_n      = ctl_q.mask;
        col_n       = ctl_q.col;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state = ST_LOAD;
                    ctl_d.row   = start_addr_i[ADDR_W-1:COL_W];
                    ctl_d.col   = start_addr_i[COL_W-1:0];
                    ctl_d.mask  = '0;
                end
            end
            ST_LOAD: begin
                if (abort_i) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.mask  = '0;
                end else begin
                    if (byte_vld_i) begin
                        st_we              = 1'b1;
                        mask_n[ctl_q.col]  = 1'b1;
                        col_n              = ctl_q.col + COL_W'(1);
                    end
                    if (commit_i) begin
                        ctl_d.state = commit_ok_i ? ST_FLUSH : ST_IDLE;
                        ctl_d.mask  = commit_ok_i ? mask_n : '0;
                    end else if (start_i) begin
                        ctl_d.row  = start_addr_i[ADDR_W-1:COL_W];
                        ctl_d.col  = start_addr_i[COL_W-1:0];
                        ctl_d.mask = '0;
                    end else begin
                        ctl_d.mask = mask_n;
                        ctl_d.col  = col_n;
                    end
                end
            end
            ST_FLUSH: begin
                if (pick_any) begin
                    ctl_d.wr_en            = 1'b1;
                    ctl_d.wr_addr          = {ctl_q.row, pick_idx};
                    ctl_d.wr_data          = pick_data;
                    ctl_d.mask[pick_idx]   = 1'b0;
                end else begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.mask  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_en_o   = ctl_q.wr_en;
    assign wr_addr_o = ctl_q.wr_addr;
    assign wr_data_o = ctl_q.wr_data;
    assign busy_o    = (ctl_q.state == ST_FLUSH);
    assign done_o    = ctl_q.done;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort_i,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              busy_o,
    input logic              done_o
);
    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o); // R8

    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |->
        (wr_addr_o[ADDR_W-1:COL_W] == $past(wr_addr_o[ADDR_W-1:COL_W]))); // R5

    AST_COL_RISING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && $past(wr_en_o)) |->
        (wr_addr_o[COL_W-1:0] > $past(wr_addr_o[COL_W-1:0]))); // R4

    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!wr_en_o && !busy_o)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R8

    AST_ABORT_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !busy_o) |=> !busy_o); // R7
endmodule

bind page_wbuf pwb_checker #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W)
) u_pwb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_i   (abort_i),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/test_page_wbuf.sv
module test_page_wbuf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] start_addr_i = '0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        commit_i = 1'b0;
    logic        commit_ok_i = 1'b0;
    logic        abort_i = 1'b0;
    logic        wr_en_o;
    logic [11:0] wr_addr_o;
    logic [7:0]  wr_data_o;
    logic        busy_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    bit order_bad = 0;
    bit prev_wr = 0;
    logic [4:0] prev_col = '0;
    logic [6:0] exp_row = '0;
    logic [7:0] got [4096];
    logic [7:0] expm [4096];

    always #10 clk = ~clk;

    page_wbuf i_page_wbuf (
        .clk, .rst_n, .start_i, .start_addr_i, .byte_vld_i, .byte_i,
        .commit_i, .commit_ok_i, .abort_i, .wr_en_o, .wr_addr_o,
        .wr_data_o, .busy_o, .done_o
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en_o) begin
                got[wr_addr_o] = wr_data_o;
                wr_cnt++;
                if (prev_wr && wr_addr_o[4:0] <= prev_col) order_bad = 1;
                if (wr_addr_o[11:5] != exp_row) order_bad = 1;
                prev_col = wr_addr_o[4:0];
            end
            prev_wr = wr_en_o;
            if (done_o) done_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
        end
    endtask

    task automatic check_mem(input string tag);
        int diffs = 0;
        for (int a = 0; a < 4096; a++) if (got[a] != expm[a]) diffs++;
        check(diffs == 0, tag, diffs, 0);
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37) + (seed * 11) + 5);
    endfunction

    task automatic t_start(input logic [11:0] a);
        @(negedge clk); start_i = 1; start_addr_i = a; exp_row = a[11:5];
        @(negedge clk); start_i = 0;
    endtask

    task automatic t_byte(input logic [7:0] d);
        @(negedge clk); byte_vld_i = 1; byte_i = d;
        @(negedge clk); byte_vld_i = 0;
    endtask

    task automatic t_commit(input bit ok);
        @(negedge clk); commit_i = 1; commit_ok_i = ok;
        @(negedge clk); commit_i = 0; commit_ok_i = 0;
    endtask

    task automatic t_abort();
        @(negedge clk); abort_i = 1;
        @(negedge clk); abort_i = 0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w0;
        int d0;
        int lens [7] = '{1, 5, 31, 32, 33, 45, 70};
        for (int a = 0; a < 4096; a++) begin got[a] = 8'h00; expm[a] = 8'h00; end

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!wr_en_o && !done_o && !busy_o, "R1 reset outputs", {wr_en_o, done_o, busy_o}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!wr_en_o && !done_o && !busy_o, "R1 after release", {wr_en_o, done_o, busy_o}, 0);

        // R2 R3 R4 R5 R6: sweep every start column over several lengths
        for (int col = 0; col < 32; col++) begin
            for (int li = 0; li < 7; li++) begin
                int n = lens[li];
                int seed = col * 8 + li;
                logic [6:0] row = 7'((col * 7 + li * 19) % 128);
                int expw = (n > 32) ? 32 : n;
                w0 = wr_cnt; d0 = done_cnt; order_bad = 0; prev_wr = 0;
                t_start({row, 5'(col)});
                for (int i = 0; i < n; i++) begin
                    t_byte(pat(i, seed));
                    expm[{row, 5'((col + i) % 32)}] = pat(i, seed);
                end
                t_commit(1);
                settle();
                check_mem("R3 R4 wrap and overwrite contents");
                check(wr_cnt - w0 == expw, "R4 one write per loaded column", wr_cnt - w0, expw);
                check(!order_bad, "R5 ascending columns on start page", order_bad, 0);
                check(done_cnt - d0 == 1, "R6 single done", done_cnt - d0, 1);
            end
        end

        // R8: busy after commit; inputs during flush ignored
        w0 = wr_cnt; d0 = done_cnt;
        t_start(12'h2A0);
        for (int i = 0; i < 32; i++) begin
            t_byte(pat(i, 900));
            expm[12'h2A0 + i] = pat(i, 900);
        end
        @(negedge clk); commit_i = 1; commit_ok_i = 1;
        @(negedge clk); commit_i = 0; commit_ok_i = 0;
        check(busy_o, "R8 busy after commit", busy_o, 1);
        start_i = 1; start_addr_i = 12'h555; byte_vld_i = 1; byte_i = 8'hEE; abort_i = 1;
        @(negedge clk); start_i = 0; byte_vld_i = 0; abort_i = 0; commit_i = 1; commit_ok_i = 1;
        @(negedge clk); commit_i = 0; commit_ok_i = 0;
        settle();
        check_mem("R8 flush unaffected by inputs");
        check(wr_cnt - w0 == 32, "R8 write count", wr_cnt - w0, 32);
        check(done_cnt - d0 == 1, "R8 done count", done_cnt - d0, 1);
        check(!busy_o, "R8 busy cleared", busy_o, 0);

        // R7: abort discards
        w0 = wr_cnt; d0 = done_cnt;
        t_start(12'h100);
        for (int i = 0; i < 6; i++) t_byte(8'hA5);
        t_abort();
        t_commit(1);
        settle();
        check(wr_cnt == w0 && done_cnt == d0, "R7 abort no write", wr_cnt - w0, 0);
        check_mem("R7 abort memory unchanged");

        // R7: commit refused
        t_start(12'h140);
        for (int i = 0; i < 4; i++) t_byte(8'h3C);
        t_commit(0);
        settle();
        check(wr_cnt == w0 && done_cnt == d0, "R7 refused commit no write", wr_cnt - w0, 0);

        // R7: abort and commit together, abort wins
        t_start(12'h180);
        t_byte(8'h11);
        @(negedge clk); abort_i = 1; commit_i = 1; commit_ok_i = 1;
        @(negedge clk); abort_i = 0; commit_i = 0; commit_ok_i = 0;
        settle();
        check(wr_cnt == w0 && done_cnt == d0, "R7 abort beats commit", wr_cnt - w0, 0);

        // R6: empty permitted commit
        t_start(12'h1C0);
        t_commit(1);
        settle();
        check(wr_cnt == w0, "R6 empty commit no write", wr_cnt - w0, 0);
        check(done_cnt - d0 == 1, "R6 empty commit done", done_cnt - d0, 1);

        // R9: idle strobes ignored
        w0 = wr_cnt; d0 = done_cnt;
        t_byte(8'h77);
        t_commit(1);
        t_abort();
        settle();
        check(wr_cnt == w0 && done_cnt == d0 && !busy_o, "R9 idle strobes ignored", wr_cnt - w0, 0);

        // R9: restart discards earlier bytes
        t_start(12'h300);
        for (int i = 0; i < 3; i++) t_byte(8'h99);
        t_start(12'h3E5);
        t_byte(8'h42); expm[12'h3E5] = 8'h42;
        t_byte(8'h43); expm[12'h3E6] = 8'h43;
        t_commit(1);
        settle();
        check(wr_cnt - w0 == 2, "R9 restart write count", wr_cnt - w0, 2);
        check_mem("R9 restart contents");

        // R10: byte with commit in same cycle
        w0 = wr_cnt;
        t_start(12'h41E);
        t_byte(8'h01); expm[12'h41E] = 8'h01;
        t_byte(8'h02); expm[12'h41F] = 8'h02;
        @(negedge clk); byte_vld_i = 1; byte_i = 8'h03; commit_i = 1; commit_ok_i = 1;
        expm[12'h400] = 8'h03;
        @(negedge clk); byte_vld_i = 0; commit_i = 0; commit_ok_i = 0;
        settle();
        check(wr_cnt - w0 == 3, "R10 byte with commit counted", wr_cnt - w0, 3);
        check_mem("R10 contents after wrap");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule